// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the pending-event flags and the per-source mask bits for a 16-bit timer with three compare channels, one capture channel and a wrap (overflow) event. The timer core hands it single-cycle event strobes that are aligned to a timer clock enable (`tick`). The block turns those strobes into sticky flags and combines each flag with its mask bit and a global interrupt enable to drive one interrupt request per source.

Software reaches the flags and masks through a small register port with one address bit. Reading the flag register has no side effects. Writing a one to a flag bit clears that flag. The interrupt controller can also clear a flag by pulsing the matching acknowledge input when it takes the vector.

A compare strobe that the timer raises because of a forced compare is kept away from the flags. The capture flag takes its set event from the external capture strobe, or from the counter-reached-TOP strobe when the waveform mode uses the capture register as TOP.

Top module: `tif_top`

## Requirements
- R1: After reset, every flag, every mask bit and every interrupt request is 0.
- R2: With `bus_addr`=0, `bus_rdata` returns the flag register: overflow at bit 0, compare A/B/C at bits 1/2/3, capture at bit 5. Bits 4, 6 and 7 always read 0. With `bus_addr`=1, it returns the mask register using the same bit positions.
- R3: A compare match strobe seen on a tick sets its compare flag at the next tick, and not on the tick of the match itself.
- R4: A compare match strobe whose `cmp_force` bit is 1 in the same cycle never sets that compare flag.
- R5: A write to the flag register clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. Writes to bits 4, 6 and 7 have no effect.
- R6: A pulse on `ack[i]` clears flag i. The index order of `ack` and `irq` is 0 overflow, 1 compare A, 2 compare B, 3 compare C, 4 capture.
- R7: With `cap_as_top`=0, the capture flag is set by `evt_capture`. With `cap_as_top`=1, it is set by `evt_top`, and `evt_capture` has no effect.
- R8: If a set event for a flag lands in the same cycle as a write-one clear or an acknowledge of that flag, the flag ends up set.
- R9: `irq[i]` is 1 exactly when flag i is set, mask bit i is 1 and `gie` is 1.
- R10: A wrap strobe seen on a tick sets the overflow flag at the next tick.
- R11: A flag can only become set on a clock where `tick` is 1. An event that is pending while `tick` is 0 waits for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Timer clock enable; the event strobes are valid when it is 1 |
| cmp_match | input | 3 | Compare match strobes for channels A, B, C (bits 0, 1, 2) |
| cmp_force | input | 3 | Marks that the same-bit match strobe comes from a forced compare |
| evt_wrap | input | 1 | Counter wrapped from its maximum value to zero |
| evt_capture | input | 1 | External capture event |
| evt_top | input | 1 | Counter reached TOP |
| cap_as_top | input | 1 | Waveform mode uses the capture register as TOP |
| gie | input | 1 | Global interrupt enable |
| ack | input | 5 | Vector acknowledge per source |
| bus_addr | input | 1 | 0 selects the flag register, 1 selects the mask register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 5 | Interrupt request per source |

## Verification
An event strobe driven in one cycle is captured into the pending stage at the next clock edge, and the flag becomes visible at the edge after that when `tick` stays high. The bench therefore samples once after the first edge, expecting the flag still clear, and once after the second edge, expecting it set. Register writes and acknowledges take effect at the next edge, while `irq` and `bus_rdata` follow the stored state combinationally in the same cycle. All stimulus changes just after the rising edge, and the monitor compares the queued expectations on the falling edge, so every comparison sees settled values.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int unsigned NCMP  = 3;
  localparam int unsigned NSRC  = NCMP + 2;
  localparam int unsigned REG_W = 8;

  // Source indices used for ack/irq vectors and internal flag storage
  localparam int unsigned SRC_OVF = 0;
  localparam int unsigned SRC_CAP = NCMP + 1;

  // Register select encoding
  localparam logic SEL_FLAGS = 1'b0;
  localparam logic SEL_MASKS = 1'b1;

  // Register bit position of a source (software-visible layout)
  function automatic int unsigned src_bit(input int unsigned s);
    if (s == SRC_CAP) return 5;
    else              return s;
  endfunction
endpackage

// File: rtl/tif_rst_sync.sv
module tif_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tif_evt_stage.sv
module tif_evt_stage #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] raw_evt,
  output logic [N-1:0] set_pulse
);
  logic [N-1:0] pend_q, pend_d;

  // Sample events on a tick; hold the sample until the next tick
  always_comb begin
    pend_d = pend_q;
    if (tick) pend_d = raw_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // Events captured on one tick are applied on the following tick
  assign set_pulse = pend_q & {N{tick}};
endmodule

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // Set dominates clear so a coincident event is never dropped
    always_comb flag_d[i] = set_pulse[i] | (flag_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/tif_top.sv
module tif_top
  import tif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCMP-1:0]  cmp_match,
  input  logic [NCMP-1:0]  cmp_force,
  input  logic             evt_wrap,
  input  logic             evt_capture,
  input  logic             evt_top,
  input  logic             cap_as_top,
  input  logic             gie,
  input  logic [NSRC-1:0]  ack,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic [NSRC-1:0]  irq
);
  logic            rst_sync_n;
  logic [NSRC-1:0] raw_evt;
  logic [NSRC-1:0] set_pulse;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] wr_bits;

  function automatic logic [REG_W-1:0] pack_reg(input logic [NSRC-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    for (int unsigned s = 0; s < NSRC; s++) r[src_bit(s)] = v[s];
    return r;
  endfunction

  function automatic logic [NSRC-1:0] unpack_reg(input logic [REG_W-1:0] r);
    logic [NSRC-1:0] v;
    for (int unsigned s = 0; s < NSRC; s++) v[s] = r[src_bit(s)];
    return v;
  endfunction

  tif_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // Event sources, forced compares filtered out
  always_comb begin
    raw_evt          = '0;
    raw_evt[SRC_OVF] = evt_wrap;
    for (int unsigned c = 0; c < NCMP; c++)
      raw_evt[1 + c] = cmp_match[c] & ~cmp_force[c];
    raw_evt[SRC_CAP] = cap_as_top ? evt_top : evt_capture;
  end

  tif_evt_stage #(.N(NSRC)) u_stage (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick),
    .raw_evt(raw_evt), .set_pulse(set_pulse)
  );

  assign wr_bits = unpack_reg(bus_wdata);
  assign clr     = ack | ((bus_wr && bus_addr == SEL_FLAGS) ? wr_bits : '0);

  tif_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .set_pulse(set_pulse), .clr(clr), .flag_q(flag_q)
  );

  always_comb begin
    mask_d = mask_q;
    if (bus_wr && bus_addr == SEL_MASKS) mask_d = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mask_q <= '0;
    else             mask_q <= mask_d;
  end

  assign bus_rdata = (bus_addr == SEL_FLAGS) ? pack_reg(flag_q) : pack_reg(mask_q);
  assign irq       = flag_q & mask_q & {NSRC{gie}};
endmodule

// File: rtl/tif_checker.sv
module tif_checker
  import tif_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tick,
  input logic             gie,
  input logic             bus_addr,
  input logic [REG_W-1:0] bus_rdata,
  input logic [NSRC-1:0]  irq,
  input logic [NSRC-1:0]  flag_q,
  input logic [NSRC-1:0]  set_pulse,
  input logic [NSRC-1:0]  clr
);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gie |-> irq == '0);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == SEL_FLAGS) |-> (bus_rdata & 8'hD0) == 8'h00);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      set_pulse[i] |=> flag_q[i]);

    // covers write-one clear (R5) and acknowledge (R6)
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (clr[i] && !set_pulse[i]) |=> !flag_q[i]);

    assert_tick_only_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(flag_q[i]) |-> $past(tick));

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      irq[i] |-> flag_q[i]);
  end
endmodule

bind tif_top tif_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .tick(tick), .gie(gie),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .flag_q(flag_q), .set_pulse(set_pulse), .clr(clr)
);

// File: tb/tif_top_test.sv
`timescale 1ns/1ps
module tif_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [2:0] cmp_match, cmp_force;
  logic       evt_wrap, evt_capture, evt_top, cap_as_top, gie;
  logic [4:0] ack;
  logic       bus_addr, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [4:0] irq;

  typedef struct {
    logic [7:0] rd;
    logic [4:0] irq;
    string      tag;
  } item_t;

  item_t sb[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  tif_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_match(cmp_match),
    .cmp_force(cmp_force), .evt_wrap(evt_wrap), .evt_capture(evt_capture),
    .evt_top(evt_top), .cap_as_top(cap_as_top), .gie(gie), .ack(ack),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: compare queued expectations on the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (bus_rdata !== it.rd || irq !== it.irq) begin
        n_fail++;
        $display("FAIL %s: rdata=%02h irq=%05b expected rdata=%02h irq=%05b",
                 it.tag, bus_rdata, irq, it.rd, it.irq);
      end
    end
  end

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic expect_state(input logic addr, input logic [7:0] rd,
                              input logic [4:0] ir, input string tag);
    item_t it;
    bus_addr = addr;
    it.rd = rd; it.irq = ir; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic bus_write(input logic addr, input logic [7:0] d);
    bus_addr = addr; bus_wr = 1'b1; bus_wdata = d;
    cyc();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; cmp_match = '0; cmp_force = '0;
    evt_wrap = 0; evt_capture = 0; evt_top = 0; cap_as_top = 0; gie = 0;
    ack = '0; bus_addr = 0; bus_wr = 0; bus_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1: reset state
    expect_state(0, 8'h00, 5'b0, "R1 flags after reset");
    expect_state(1, 8'h00, 5'b0, "R1 masks after reset");

    // R2: mask register layout
    bus_write(1, 8'hFF);
    expect_state(1, 8'h2F, 5'b0, "R2 mask readback");

    // R3: compare A sets one tick later
    cmp_match = 3'b001; cyc(); cmp_match = '0;
    expect_state(0, 8'h00, 5'b0, "R3 not set on match tick");
    cyc();
    expect_state(0, 8'h02, 5'b0, "R3 compare A flag");

    // R9: gating by gie and mask
    gie = 1'b1;
    expect_state(0, 8'h02, 5'b00010, "R9 irq A asserted");
    bus_write(1, 8'h00);
    expect_state(0, 8'h02, 5'b00000, "R9 mask cleared");
    bus_write(1, 8'hFF);

    // R4: forced compare C ignored, real compare C sets
    cmp_match = 3'b100; cmp_force = 3'b100; cyc(); cmp_match = '0; cmp_force = '0;
    cyc(2);
    expect_state(0, 8'h02, 5'b00010, "R4 forced compare no flag");
    cmp_match = 3'b100; cyc(); cmp_match = '0; cyc();
    expect_state(0, 8'h0A, 5'b01010, "R3 compare C flag");

    // R5: write-one clear
    bus_write(0, 8'h00);
    expect_state(0, 8'h0A, 5'b01010, "R5 write zero keeps flags");
    bus_write(0, 8'h02);
    expect_state(0, 8'h08, 5'b01000, "R5 write one clears A");
    bus_write(0, 8'hD0);
    expect_state(0, 8'h08, 5'b01000, "R5 reserved bits no effect");

    // R6: acknowledge clears
    ack = 5'b01000; cyc(); ack = '0;
    expect_state(0, 8'h00, 5'b00000, "R6 ack clears C");

    // R10: overflow
    evt_wrap = 1'b1; cyc(); evt_wrap = 1'b0;
    expect_state(0, 8'h00, 5'b00000, "R10 not set on wrap tick");
    cyc();
    expect_state(0, 8'h01, 5'b00001, "R10 overflow flag");

    // R7: capture source
    evt_capture = 1'b1; cyc(); evt_capture = 1'b0; cyc();
    expect_state(0, 8'h21, 5'b10001, "R7 external capture");
    bus_write(0, 8'h21);
    expect_state(0, 8'h00, 5'b00000, "R5 clear capture and overflow");
    cap_as_top = 1'b1;
    evt_capture = 1'b1; cyc(); evt_capture = 1'b0; cyc(2);
    expect_state(0, 8'h00, 5'b00000, "R7 capture ignored in TOP mode");
    evt_top = 1'b1; cyc(); evt_top = 1'b0; cyc();
    expect_state(0, 8'h20, 5'b10000, "R7 TOP sets capture flag");

    // R2: all flags, reserved bits read zero
    cmp_match = 3'b111; evt_wrap = 1'b1; evt_top = 1'b1; cyc();
    cmp_match = '0; evt_wrap = 1'b0; evt_top = 1'b0; cyc();
    expect_state(0, 8'h2F, 5'b11111, "R2 full flag layout");
    bus_write(0, 8'hFF);
    expect_state(0, 8'h00, 5'b00000, "R5 clear all");

    // R8: set beats same-cycle clear and ack
    cmp_match = 3'b010; cyc(); cmp_match = '0;
    bus_addr = 0; bus_wr = 1'b1; bus_wdata = 8'h04; ack = 5'b00100;
    cyc();
    bus_wr = 1'b0; bus_wdata = '0; ack = '0;
    expect_state(0, 8'h04, 5'b00100, "R8 set wins over clear");

    // R11: slow tick
    tick = 1'b1; cmp_match = 3'b001; cyc(); cmp_match = '0; tick = 1'b0;
    cyc(3);
    expect_state(0, 8'h04, 5'b00100, "R11 held while tick low");
    tick = 1'b1; cyc(); tick = 1'b0;
    expect_state(0, 8'h06, 5'b00110, "R11 set on next tick");
    tick = 1'b1;

    cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule